// File: doc/BRIEF.md
# Three-Wire Serial Control Bus Master

This block is the master side of a three-wire control bus made of a serial clock, a bidirectional data line and a mode line. A host hands it one request at a time: a six-bit device number, a two-bit register-type selector, a direction, a byte count and up to `MAX_BYTES` bytes of write data. The master frames the request on the bus and finishes it with a one-cycle done strobe. For a read, the done strobe comes with the bytes it collected.

A transfer opens with all three lines driven high for one cycle. The address byte follows with the mode line low, then the data bytes with the mode line high. Every byte goes out least significant bit first. Before the first data byte there is no extra clock pulse. Each later data byte is preceded by a clock-low halt pulse, which separates the bytes. On a read the data-line driver is switched off once the address byte is done, and the master samples the target's bits at the end of each clock-low phase. The transfer closes by pulling all lines low. Every delay is taken from a parameter: clock low, clock high, mode setup, mode hold and halt.

Top module: `ctl3w_master`

## Requirements
- R1: After reset, and whenever `req_ready` is high, `bus_clk`, `bus_mode` and `bus_dat_oe` are low. `req_ready` is high after reset.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), `bus_clk`, `bus_mode`, `bus_dat_o` and `bus_dat_oe` are all high.
- R3: The first byte on the bus is the address byte `{req_dev, req_sel}`, with the device number in bits 7..2 and the selector in bits 1..0. It is sent least significant bit first while `bus_mode` is low and `bus_dat_oe` is high.
- R4: Data is valid at each rising edge of `bus_clk`. Every bit has a clock-low time of `T_LOW` cycles, except the first address bit, whose low time is `T_SETUP + T_LOW` because the clock is pulled low for the mode setup interval before the address byte.
- R5: On a write, data byte k is `req_wdata[8k+7:8k]`. It is sent least significant bit first with `bus_mode` high and `bus_dat_oe` high.
- R6: The first data byte directly follows the address byte, with no extra clock pulse. Each later data byte is preceded by one clock-low pulse of exactly `T_HALT` cycles, during which `bus_mode` stays high.
- R7: On a read, `bus_dat_oe` is low for every data bit and every halt pulse. The bit on `bus_dat_i` is taken at the end of each clock-low phase. Byte k appears on `rsp_rdata[8k+7:8k]` with its first bus bit in bit 8k. Bytes beyond the count read as zero.
- R8: At the end of a transfer, `rsp_done` is high for exactly one cycle, and in that cycle the bus lines are low. `req_ready` goes high in the next cycle. `req_valid` has no effect while `req_ready` is low, including the done cycle.
- R9: A byte count of zero sends only the address byte and then ends the transfer.
- R10: A byte count larger than `MAX_BYTES` is treated as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle; a request is taken when valid is high in this state |
| req_dev | input | 6 | Device number, address byte bits 7..2 |
| req_sel | input | 2 | Register-type selector, address byte bits 1..0 |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Number of data bytes (0 to 2^LEN_W-1, clamped to MAX_BYTES) |
| req_wdata | input | MAX_BYTES*8 | Write bytes, byte k in bits 8k+7..8k |
| rsp_done | output | 1 | One-cycle end-of-transfer strobe |
| rsp_rdata | output | MAX_BYTES*8 | Read bytes, valid from the done cycle until the next accept |
| bus_clk | output | 1 | Serial clock |
| bus_mode | output | 1 | Mode line: low for the address byte, high for data |
| bus_dat_o | output | 1 | Data line output value |
| bus_dat_oe | output | 1 | Data line output enable |
| bus_dat_i | input | 1 | Data line input value |

## Verification
Two things can fall in the same cycle: the end of a transfer, when `rsp_done` pulses and the lines drop, and a fresh `req_valid` from the host. The bench provokes this by holding `req_valid` high with different request fields through the whole of one write, the done cycle included, and dropping it only after the done cycle. The bench then checks three things. The bytes on the bus must belong to the original request. Done must pulse once. The lines must stay low with `req_ready` high for a stretch of idle cycles afterwards, which shows that no second transfer was started.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPEN,
        PH_SETUP,
        PH_BLO,
        PH_BHI,
        PH_HOLD,
        PH_HALT,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic scl;
        logic mode;
        logic oe;
    } lines_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bus line levels for a given phase. addr_ph selects the address byte,
    // rd selects turnaround of the data line during data bytes.
    function automatic lines_t drive_lines(phase_t ph, logic addr_ph, logic rd);
        lines_t l;
        l.scl  = 1'b0;
        l.mode = 1'b0;
        l.oe   = 1'b0;
        case (ph)
            PH_IDLE, PH_DONE: ;
            PH_OPEN: begin
                l.scl  = 1'b1;
                l.mode = 1'b1;
                l.oe   = 1'b1;
            end
            default: begin
                l.mode = ~addr_ph;
                l.oe   = addr_ph | ~rd;
                if (ph == PH_BHI || ph == PH_HOLD)
                    l.scl = 1'b1;
                else if (ph == PH_SETUP)
                    l.scl = ~addr_ph;
                else
                    l.scl = 1'b0;
            end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ctl3w_delay.sv
module ctl3w_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ctl3w_rxcap.sv
module ctl3w_rxcap #(
    parameter int MAX_BYTES = 4,
    parameter int BIDX_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   sample,
    input  logic [BIDX_W-1:0]      byte_idx,
    input  logic [2:0]             bit_idx,
    input  logic                   din,
    output logic [MAX_BYTES*8-1:0] rdata
);

    logic [MAX_BYTES*8-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            rdata_q <= '0;
        else if (sample)
            rdata_q[{byte_idx, bit_idx}] <= din;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ctl3w_seq.sv
module ctl3w_seq
    import ctl3w_pkg::*;
#(
    parameter int T_LOW     = 2,
    parameter int T_HIGH    = 2,
    parameter int T_SETUP   = 3,
    parameter int T_HOLD    = 2,
    parameter int T_HALT    = 7,
    parameter int MAX_BYTES = 4,
    parameter int LEN_W     = 3,
    parameter int BIDX_W    = 2,
    parameter int CNT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [5:0]             req_dev,
    input  logic [1:0]             req_sel,
    input  logic                   req_rd,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [MAX_BYTES*8-1:0] req_wdata,
    input  logic                   tick,
    output logic                   load,
    output logic [CNT_W-1:0]       load_val,
    output logic                   ready,
    output logic                   done,
    output logic                   rx_clear,
    output logic                   rx_sample,
    output logic [BIDX_W-1:0]      byte_idx,
    output logic [2:0]             bit_idx,
    output lines_t                 lines,
    output logic                   sda
);

    localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] LD_HIGH  = CNT_W'(T_HIGH - 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LD_HALT  = CNT_W'(T_HALT - 1);
    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_BYTES);

    phase_t                 ph_q, ph_d;
    logic [7:0]             addr_q;
    logic                   rd_q;
    logic [LEN_W-1:0]       len_q;
    logic [MAX_BYTES*8-1:0] wdata_q;
    logic [BIDX_W-1:0]      byte_q;
    logic [2:0]             bit_q;
    logic                   addr_ph_q;
    logic                   sda_q;

    logic [7:0] cur_byte;
    logic       last_bit;
    logic       last_byte;
    logic       no_data;

    assign cur_byte  = addr_ph_q ? addr_q : wdata_q[{byte_q, 3'b000} +: 8];
    assign last_bit  = (bit_q == 3'd7);
    assign last_byte = ((LEN_W'(byte_q) + LEN_W'(1)) == len_q);
    assign no_data   = (len_q == '0);

    // Next phase and timer reload
    always_comb begin
        ph_d     = ph_q;
        load     = 1'b0;
        load_val = '0;
        case (ph_q)
            PH_IDLE: if (req_valid) begin
                ph_d = PH_OPEN;
                load = 1'b1;
            end
            PH_OPEN: if (tick) begin
                ph_d     = PH_SETUP;
                load     = 1'b1;
                load_val = LD_SETUP;
            end
            PH_SETUP: if (tick) begin
                ph_d     = PH_BLO;
                load     = 1'b1;
                load_val = LD_LOW;
            end
            PH_BLO: if (tick) begin
                ph_d     = PH_BHI;
                load     = 1'b1;
                load_val = LD_HIGH;
            end
            PH_BHI: if (tick) begin
                load = 1'b1;
                if (last_bit) begin
                    ph_d     = PH_HOLD;
                    load_val = LD_HOLD;
                end else begin
                    ph_d     = PH_BLO;
                    load_val = LD_LOW;
                end
            end
            PH_HOLD: if (tick) begin
                load = 1'b1;
                if (addr_ph_q) begin
                    if (no_data) begin
                        ph_d = PH_DONE;
                    end else begin
                        ph_d     = PH_SETUP;
                        load_val = LD_SETUP;
                    end
                end else if (last_byte) begin
                    ph_d = PH_DONE;
                end else begin
                    ph_d     = PH_HALT;
                    load_val = LD_HALT;
                end
            end
            PH_HALT: if (tick) begin
                ph_d     = PH_SETUP;
                load     = 1'b1;
                load_val = LD_SETUP;
            end
            PH_DONE: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Request capture, byte and bit position, data line value
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            len_q     <= '0;
            wdata_q   <= '0;
            byte_q    <= '0;
            bit_q     <= '0;
            addr_ph_q <= 1'b0;
            sda_q     <= 1'b0;
        end else begin
            ph_q <= ph_d;
            case (ph_q)
                PH_IDLE: if (req_valid) begin
                    addr_q    <= {req_dev, req_sel};
                    rd_q      <= req_rd;
                    len_q     <= (req_len > LEN_MAX) ? LEN_MAX : req_len;
                    wdata_q   <= req_wdata;
                    byte_q    <= '0;
                    bit_q     <= '0;
                    addr_ph_q <= 1'b1;
                    sda_q     <= 1'b1;
                end
                PH_SETUP: if (tick) begin
                    bit_q <= '0;
                    sda_q <= cur_byte[0];
                end
                PH_BHI: if (tick && !last_bit) begin
                    bit_q <= bit_q + 3'd1;
                    sda_q <= cur_byte[bit_q + 3'd1];
                end
                PH_HOLD: if (tick) begin
                    if (addr_ph_q) begin
                        addr_ph_q <= 1'b0;
                        byte_q    <= '0;
                    end else if (!last_byte) begin
                        byte_q <= byte_q + 1'b1;
                    end
                    if (ph_d == PH_DONE)
                        sda_q <= 1'b0;
                end
                PH_DONE: begin
                    addr_ph_q <= 1'b0;
                    sda_q     <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign ready     = (ph_q == PH_IDLE);
    assign done      = (ph_q == PH_DONE);
    assign rx_clear  = (ph_q == PH_IDLE) && req_valid;
    assign rx_sample = (ph_q == PH_BLO) && tick && !addr_ph_q && rd_q;
    assign byte_idx  = byte_q;
    assign bit_idx   = bit_q;
    assign lines     = drive_lines(ph_q, addr_ph_q, rd_q);
    assign sda       = sda_q;

endmodule

// File: rtl/ctl3w_master.sv
module ctl3w_master
    import ctl3w_pkg::*;
#(
    parameter int T_LOW     = 2,
    parameter int T_HIGH    = 2,
    parameter int T_SETUP   = 3,
    parameter int T_HOLD    = 2,
    parameter int T_HALT    = 7,
    parameter int MAX_BYTES = 4,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [5:0]             req_dev,
    input  logic [1:0]             req_sel,
    input  logic                   req_rd,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [MAX_BYTES*8-1:0] req_wdata,
    output logic                   rsp_done,
    output logic [MAX_BYTES*8-1:0] rsp_rdata,
    output logic                   bus_clk,
    output logic                   bus_mode,
    output logic                   bus_dat_o,
    output logic                   bus_dat_oe,
    input  logic                   bus_dat_i
);

    localparam int DMAX   = max2(max2(max2(T_LOW, T_HIGH), max2(T_SETUP, T_HOLD)), T_HALT);
    localparam int CNT_W  = $clog2(DMAX + 1);
    localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic              tick;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              rx_clear;
    logic              rx_sample;
    logic [BIDX_W-1:0] byte_idx;
    logic [2:0]        bit_idx;
    lines_t            lines;
    logic              sda;

    ctl3w_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (tick)
    );

    ctl3w_seq #(
        .T_LOW     (T_LOW),
        .T_HIGH    (T_HIGH),
        .T_SETUP   (T_SETUP),
        .T_HOLD    (T_HOLD),
        .T_HALT    (T_HALT),
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W),
        .BIDX_W    (BIDX_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_dev   (req_dev),
        .req_sel   (req_sel),
        .req_rd    (req_rd),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .tick      (tick),
        .load      (load),
        .load_val  (load_val),
        .ready     (req_ready),
        .done      (rsp_done),
        .rx_clear  (rx_clear),
        .rx_sample (rx_sample),
        .byte_idx  (byte_idx),
        .bit_idx   (bit_idx),
        .lines     (lines),
        .sda       (sda)
    );

    ctl3w_rxcap #(
        .MAX_BYTES (MAX_BYTES),
        .BIDX_W    (BIDX_W)
    ) u_rxcap (
        .clk      (clk),
        .rst      (rst),
        .clear    (rx_clear),
        .sample   (rx_sample),
        .byte_idx (byte_idx),
        .bit_idx  (bit_idx),
        .din      (bus_dat_i),
        .rdata    (rsp_rdata)
    );

    assign bus_clk    = lines.scl;
    assign bus_mode   = lines.mode;
    assign bus_dat_oe = lines.oe;
    assign bus_dat_o  = sda;

endmodule

// File: rtl/ctl3w_master_chk.sv
module ctl3w_master_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic bus_clk,
    input logic bus_mode,
    input logic bus_dat_o,
    input logic bus_dat_oe
);

    // R1
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_clk && !bus_mode && !bus_dat_oe));

    // R2
    open_all_high_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bus_clk && bus_mode && bus_dat_o && bus_dat_oe));

    // R8
    done_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!bus_clk && !bus_mode && !bus_dat_oe && !req_ready));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    // R7
    turnaround_data_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_dat_oe && !req_ready && !rsp_done) |-> bus_mode);

endmodule

bind ctl3w_master ctl3w_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .bus_clk    (bus_clk),
    .bus_mode   (bus_mode),
    .bus_dat_o  (bus_dat_o),
    .bus_dat_oe (bus_dat_oe)
);

// File: tb/ctl3w_master_test.sv
module ctl3w_master_test;

    localparam int TL = 2;
    localparam int TH = 2;
    localparam int TS = 3;
    localparam int TO = 2;
    localparam int TA = 7;
    localparam int MB = 4;
    localparam int LW = $clog2(MB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [5:0]    req_dev = '0;
    logic [1:0]    req_sel = '0;
    logic          req_rd = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [MB*8-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [MB*8-1:0] rsp_rdata;
    logic          bus_clk, bus_mode, bus_dat_o, bus_dat_oe;
    logic          bus_dat_i = 1'b0;

    ctl3w_master #(
        .T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(TO), .T_HALT(TA), .MAX_BYTES(MB)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_sel(req_sel), .req_rd(req_rd), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_dat_o(bus_dat_o),
        .bus_dat_oe(bus_dat_oe), .bus_dat_i(bus_dat_i)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    // Bus monitor and read responder (target model)
    int   ev_cnt = 0;
    int   ev_low [64];
    logic ev_mode [64];
    logic ev_dat [64];
    logic ev_oe [64];
    int   low_len = 0;
    logic prev_scl = 1'b0;
    int   rd_seen = 0;
    logic [31:0] resp_bits = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst || req_ready) begin
            low_len = 0;
            rd_seen = 0;
        end else if (!bus_clk) begin
            low_len++;
        end else begin
            if (!prev_scl && low_len > 0 && ev_cnt < 64) begin
                ev_low[ev_cnt]  = low_len;
                ev_mode[ev_cnt] = bus_mode;
                ev_dat[ev_cnt]  = bus_dat_o;
                ev_oe[ev_cnt]   = bus_dat_oe;
                if (!bus_dat_oe && low_len != TA) rd_seen++;
                ev_cnt++;
            end
            low_len = 0;
        end
        prev_scl = bus_clk;
        bus_dat_i = (rd_seen < 32) ? resp_bits[rd_seen] : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    endtask

    always @(negedge clk) begin
        if (!finished && cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    // One full transfer. poke keeps req_valid high with other fields while busy.
    task automatic run_txn(input logic [5:0] dev, input logic [1:0] sel, input logic rd,
                           input int len, input logic [31:0] wdata,
                           input logic [31:0] resp, input bit poke, input string name);
        int  len_eff;
        int  n_exp;
        int  idx;
        int  bad_mode;
        int  bad_low;
        int  bad_oe;
        int  done_cycles;
        int  waited;
        logic [7:0]  abyte;
        logic [7:0]  seen;
        logic [31:0] exp_rd;
        len_eff = (len > MB) ? MB : len;
        n_exp = 8 + len_eff * 8 + ((len_eff > 1) ? len_eff - 1 : 0);
        @(negedge clk);
        ev_cnt = 0;
        resp_bits = resp;
        req_dev = dev; req_sel = sel; req_rd = rd;
        req_len = LW'(len); req_wdata = wdata;
        req_valid = 1'b1;
        @(negedge clk);
        // R2: one cycle after accept all lines high
        chk(bus_clk && bus_mode && bus_dat_o && bus_dat_oe && !req_ready, "R2",
            {name, " open lines"}, {bus_clk, bus_mode, bus_dat_o, bus_dat_oe}, 4'hF);
        if (poke) begin
            req_dev = ~dev; req_sel = ~sel; req_rd = ~rd; req_wdata = ~wdata;
        end else begin
            req_valid = 1'b0;
        end
        done_cycles = 0;
        waited = 0;
        while (!rsp_done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        // R8: lines low in done cycle
        chk(rsp_done && !bus_clk && !bus_mode && !bus_dat_oe, "R8", {name, " done lines"},
            {rsp_done, bus_clk, bus_mode, bus_dat_oe}, 4'h8);
        if (rd) begin
            exp_rd = '0;
            for (int k = 0; k < len_eff; k++) exp_rd[8*k +: 8] = resp[8*k +: 8];
            // R7: read bytes assembled in order
            chk(rsp_rdata == exp_rd, "R7", {name, " read data"}, rsp_rdata, exp_rd);
        end
        while (rsp_done) begin
            done_cycles++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R8: single done, then ready
        chk(done_cycles == 1 && req_ready, "R8", {name, " done width/ready"},
            done_cycles, 1);
        // Event checks
        chk(ev_cnt == n_exp, "R6", {name, " clock edge count"}, ev_cnt, n_exp);
        if (ev_cnt == n_exp) begin
            abyte = {dev, sel};
            seen = '0;
            bad_mode = 0; bad_low = 0; bad_oe = 0;
            for (int i = 0; i < 8; i++) begin
                seen[i] = ev_dat[i];
                if (ev_mode[i] !== 1'b0) bad_mode++;
                if (ev_oe[i] !== 1'b1) bad_oe++;
                if (ev_low[i] != ((i == 0) ? TS + TL : TL)) bad_low++;
            end
            // R3: address byte LSB first, mode low
            chk(seen == abyte, "R3", {name, " address byte"}, seen, abyte);
            chk(bad_mode == 0 && bad_oe == 0, "R3", {name, " address mode/oe"},
                bad_mode + bad_oe, 0);
            idx = 8;
            for (int k = 0; k < len_eff; k++) begin
                if (k == 0) begin
                    // R6: no halt before first data byte
                    chk(ev_low[idx] == TL, "R6", {name, " first data no halt"},
                        ev_low[idx], TL);
                end else begin
                    // R6: halt pulse before later bytes
                    chk(ev_low[idx] == TA && ev_mode[idx] == 1'b1, "R6",
                        {name, " halt pulse"}, ev_low[idx], TA);
                    if (rd && ev_oe[idx] !== 1'b0) bad_oe++;
                    idx++;
                end
                seen = '0;
                for (int i = 0; i < 8; i++) begin
                    seen[i] = ev_dat[idx];
                    if (ev_mode[idx] !== 1'b1) bad_mode++;
                    if (ev_oe[idx] !== !rd) bad_oe++;
                    if (ev_low[idx] != TL) bad_low++;
                    idx++;
                end
                if (!rd) begin
                    // R5: write byte LSB first
                    chk(seen == wdata[8*k +: 8], "R5", {name, " write byte"},
                        seen, wdata[8*k +: 8]);
                end
            end
            // R4: clock low times
            chk(bad_low == 0, "R4", {name, " clock low times"}, bad_low, 0);
            if (rd)
                chk(bad_mode == 0 && bad_oe == 0, "R7", {name, " read mode/oe"},
                    bad_mode + bad_oe, 0);
            else
                chk(bad_mode == 0 && bad_oe == 0, "R5", {name, " write mode/oe"},
                    bad_mode + bad_oe, 0);
        end
    endtask

    task automatic test_reset();
        // R1
        chk(req_ready && !bus_clk && !bus_mode && !bus_dat_oe && !rsp_done, "R1",
            "reset state", {req_ready, bus_clk, bus_mode, bus_dat_oe, rsp_done}, 5'h10);
    endtask

    task automatic test_write_one();
        run_txn(6'h2A, 2'd2, 1'b0, 1, 32'h0000_00C5, '0, 1'b0, "wr1");
    endtask

    task automatic test_write_three();
        run_txn(6'h15, 2'd1, 1'b0, 3, 32'h0069_3EA1, '0, 1'b0, "wr3");
    endtask

    task automatic test_read_two();
        run_txn(6'h3F, 2'd0, 1'b1, 2, '0, 32'hFFFF_935A, 1'b0, "rd2");
    endtask

    task automatic test_read_four();
        run_txn(6'h01, 2'd3, 1'b1, 4, '0, 32'h81C3_E70F, 1'b0, "rd4");
    endtask

    task automatic test_len_zero();
        // R9: address only
        run_txn(6'h24, 2'd1, 1'b0, 0, 32'hDEAD_BEEF, '0, 1'b0, "R9 len0");
    endtask

    task automatic test_len_clamp();
        // R10: count 7 sends four bytes
        run_txn(6'h0B, 2'd2, 1'b0, 7, 32'h7E18_2DB4, '0, 1'b0, "R10 clamp");
    endtask

    task automatic test_busy_ignore();
        int activity;
        run_txn(6'h33, 2'd0, 1'b0, 2, 32'h0000_A55A, '0, 1'b1, "R8 busy");
        activity = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!req_ready || bus_clk || bus_mode || bus_dat_oe) activity++;
        end
        // R8: request seen while busy did not start a transfer
        chk(activity == 0, "R8", "no transfer after busy valid", activity, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_write_one();
        test_write_three();
        test_read_two();
        test_read_four();
        test_len_zero();
        test_len_clamp();
        test_busy_ignore();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule